// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

A synthesizable stand-in for an asynchronous static RAM with a 16-bit data path split into two byte lanes. Active-low controls select the part, request a write, enable the output, and pick the lower and upper byte lanes. A write stores only the lanes whose enable is asserted. A read presents the stored bytes of the enabled lanes and leaves every other lane released.

The bidirectional data pins are split into a data-in bus, a data-out bus and one output-enable bit per lane, so a pad ring or a bench can rebuild the tristate bus. Writes are taken on the rising edge of a simulation clock that runs much faster than any real access, which stands in for level-sensitive storage. Reads are combinational from the array. The array depth is a parameter (1024 words by default). Address bits above the depth are ignored, so higher addresses alias onto the stored words. Contents after power-up are undefined.

Top module: `byte_lane_sram`

## Requirements
- R1: When rstN=1, ceN=0 and weN=0 at a rising clk edge, every lane g whose enable is low (lane 0 = lbN, lane 1 = ubN) stores its byte of dataIn at the addressed word. A lane whose enable is high keeps its previous byte.
- R2: When rstN=1, ceN=0, weN=1 and oeN=0, laneOe[g]=1 for each lane whose enable is low, and that lane of dataOut shows the stored byte in the same cycle, with no clock edge needed.
- R3: Lane 0 is dataOut/dataIn bits 7:0 and laneOe[0], gated by lbN. Lane 1 is bits 15:8 and laneOe[1], gated by ubN. The two lanes act independently.
- R4: laneOe is 0 whenever ceN=1 or oeN=1.
- R5: laneOe is 0 whenever lbN=1 and ubN=1, and no byte is stored in that case.
- R6: laneOe is 0 during any write (ceN=0, weN=0), even when oeN=0.
- R7: Any lane with laneOe[g]=0 shows 8'h00 on its dataOut bits.
- R8: Only the low log2(Depth) address bits select a word. Addresses that differ only above those bits reach the same word.
- R9: While rstN=0, nothing is stored and laneOe is 0. The array keeps its contents through reset.
- R10: A write to one word leaves every other word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the modelled access |
| rstN | input | 1 | Active-low reset; blocks writes and releases the bus |
| addr | input | AddrW (18) | Word address; bits at or above log2(Depth) are ignored |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| lbN | input | 1 | Active-low enable for lane 0 (bits 7:0) |
| ubN | input | 1 | Active-low enable for lane 1 (bits 15:8) |
| dataIn | input | 16 | Write data from the bus |
| dataOut | output | 16 | Read data; 0 on lanes not driven |
| laneOe | output | 2 | Per-lane output enable for the tristate bus |

## Verification
The assertions assume that the controls are stable between rising clk edges and that reset is held for at least one edge before any access, so the one-cycle look-back at a write sees the address and data actually committed. The bench changes every input only on the falling edge and holds it through the next rising edge. It reads only words it has written first, so undefined power-up contents never reach a compare. In the exhaustive sweep over the control inputs, dataIn equals the stored word, so the writes that sweep provokes cannot disturb the values expected later.

// File: rtl/byte_lane_sram_pkg.sv
`timescale 1ns/1ps
package byte_lane_sram_pkg;
  localparam int LaneW    = 8;
  localparam int NumLanes = 2;
  localparam int DataW    = LaneW * NumLanes;

  // Strobes from the control decoder to the storage datapath
  typedef struct packed {
    logic [NumLanes-1:0] write;  // commit this lane at the next edge
    logic [NumLanes-1:0] drive;  // present this lane on the bus
  } strobe_t;
endpackage

// File: rtl/byte_lane_sram_ctrl.sv
`timescale 1ns/1ps
module byte_lane_sram_ctrl
  import byte_lane_sram_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                weN,
  input  logic                oeN,
  input  logic [NumLanes-1:0] laneEnN,
  output strobe_t             strb
);
  logic selected;
  logic writeCyc;
  logic readCyc;

  assign selected = rstN & ~ceN;
  assign writeCyc = selected & ~weN;
  assign readCyc  = selected & weN & ~oeN;

  for (genvar g = 0; g < NumLanes; g++) begin : gLane
    assign strb.write[g] = writeCyc & ~laneEnN[g];
    assign strb.drive[g] = readCyc & ~laneEnN[g];

    // R5
    lane_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      laneEnN[g] |-> (!strb.write[g] && !strb.drive[g]));
  end

  // R4
  deselect_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> (strb.drive == '0));

  // R6
  write_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.write != '0) |-> (strb.drive == '0));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (strb.write == '0 && strb.drive == '0));
endmodule

// File: rtl/byte_lane_sram_datapath.sv
`timescale 1ns/1ps
module byte_lane_sram_datapath
  import byte_lane_sram_pkg::*;
#(
  parameter int Depth = 1024,
  localparam int IdxW = $clog2(Depth)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IdxW-1:0]     idx,
  input  strobe_t             strb,
  input  logic [DataW-1:0]    dataIn,
  output logic [DataW-1:0]    dataOut,
  output logic [NumLanes-1:0] laneOe
);
  for (genvar g = 0; g < NumLanes; g++) begin : gLane
    logic [LaneW-1:0] laneMem [Depth];
    logic [LaneW-1:0] laneRd;

    always_ff @(posedge clk) begin
      if (strb.write[g]) laneMem[idx] <= dataIn[g*LaneW +: LaneW];
    end

    assign laneRd = laneMem[idx];
    assign dataOut[g*LaneW +: LaneW] = strb.drive[g] ? laneRd : '0;
    assign laneOe[g] = strb.drive[g];

    // R1
    write_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.write[g] |=> (laneMem[$past(idx)] == $past(dataIn[g*LaneW +: LaneW])));

    // R7
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      !laneOe[g] |-> (dataOut[g*LaneW +: LaneW] == '0));
  end
endmodule

// File: rtl/byte_lane_sram.sv
`timescale 1ns/1ps
module byte_lane_sram
  import byte_lane_sram_pkg::*;
#(
  parameter int Depth = 1024,
  parameter int AddrW = 18,
  localparam int IdxW = $clog2(Depth)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [AddrW-1:0]    addr,
  input  logic                ceN,
  input  logic                weN,
  input  logic                oeN,
  input  logic                lbN,
  input  logic                ubN,
  input  logic [DataW-1:0]    dataIn,
  output logic [DataW-1:0]    dataOut,
  output logic [NumLanes-1:0] laneOe
);
  strobe_t               strb;
  logic [IdxW-1:0]       idx;
  logic [AddrW-IdxW-1:0] unusedAddrHi;

  assign idx          = addr[IdxW-1:0];
  assign unusedAddrHi = addr[AddrW-1:IdxW];

  byte_lane_sram_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .weN     (weN),
    .oeN     (oeN),
    .laneEnN ({ubN, lbN}),
    .strb    (strb)
  );

  byte_lane_sram_datapath #(.Depth(Depth)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .idx     (idx),
    .strb    (strb),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .laneOe  (laneOe)
  );

  // R2
  read_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && weN && !oeN) |-> (laneOe == ~{ubN, lbN}));
endmodule

// File: tb/tb_byte_lane_sram.sv
`timescale 1ns/1ps
module tb_byte_lane_sram;
  localparam int Depth = 1024;
  localparam int AddrW = 18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] addr = '0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1, lbN = 1'b1, ubN = 1'b1;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic [1:0]  laneOe;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] shadow [Depth];

  byte_lane_sram #(.Depth(Depth), .AddrW(AddrW)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .weN(weN), .oeN(oeN),
    .lbN(lbN), .ubN(ubN), .dataIn(dataIn), .dataOut(dataOut), .laneOe(laneOe)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] pat(input int i, input int salt);
    return 16'((i * 40503 + salt * 7919 + 16'h1234) & 16'hFFFF);
  endfunction

  task automatic check(input bit ok, input string req, input logic [17:0] act,
                       input logic [17:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [17:0] a, input logic [15:0] d,
                         input logic lb, input logic ub);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 0; weN = 0; oeN = 1; lbN = lb; ubN = ub;
  endtask

  // Read with given lane enables, compare against expectation built from word w
  task automatic doRead(input logic [17:0] a, input logic lb, input logic ub,
                        input logic [15:0] w, input string req);
    logic [1:0]  expOe;
    logic [15:0] expD;
    @(negedge clk);
    addr = a; ceN = 0; weN = 1; oeN = 0; lbN = lb; ubN = ub;
    #1;
    expOe = {~ub, ~lb};
    expD  = {expOe[1] ? w[15:8] : 8'h00, expOe[0] ? w[7:0] : 8'h00};
    check({laneOe, dataOut} === {expOe, expD}, req,
          {laneOe, dataOut}, {expOe, expD});
  endtask

  task automatic idle();
    @(negedge clk);
    ceN = 1; weN = 1; oeN = 1; lbN = 1; ubN = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    // R9: reset state, bus released even with read controls asserted
    repeat (2) @(negedge clk);
    ceN = 0; weN = 1; oeN = 0; lbN = 0; ubN = 0;
    #1 check(laneOe === 2'b00 && dataOut === 16'h0, "R9 reset release",
             {laneOe, dataOut}, 18'h0);
    idle();
    rstN = 1;

    // R1 R10: full-width write of every word, then read every word
    for (int i = 0; i < Depth; i++) begin
      shadow[i] = pat(i, 0);
      doWrite(18'(i), shadow[i], 0, 0);
    end
    for (int i = 0; i < Depth; i++) doRead(18'(i), 0, 0, shadow[i], "R1 R10 full read");

    // R3: lane-only reads
    for (int i = 0; i < 32; i++) begin
      doRead(18'(i), 0, 1, shadow[i], "R3 lower lane read");
      doRead(18'(i), 1, 0, shadow[i], "R3 upper lane read");
    end

    // R1 R3: masked writes merge into existing words
    for (int i = 0; i < 128; i++) begin
      logic [15:0] d;
      d = pat(i, 3);
      if (i % 2 == 0) begin
        doWrite(18'(i), d, 0, 1);
        shadow[i][7:0] = d[7:0];
      end else begin
        doWrite(18'(i), d, 1, 0);
        shadow[i][15:8] = d[15:8];
      end
    end
    for (int i = 0; i < 128; i++) doRead(18'(i), 0, 0, shadow[i], "R1 masked merge");

    // R5: write with both lanes disabled stores nothing
    doWrite(18'd200, ~shadow[200], 1, 1);
    #1 check(laneOe === 2'b00, "R5 no drive", {16'h0, laneOe}, 18'h0);
    doRead(18'd200, 0, 0, shadow[200], "R5 no store");

    // R2 R4 R5 R6 R7: exhaustive control sweep; dataIn equals stored word
    for (int a = 300; a < 304; a++) begin
      for (int c = 0; c < 32; c++) begin
        logic [1:0]  expOe;
        logic [15:0] expD;
        logic        rd;
        @(negedge clk);
        addr = 18'(a); dataIn = shadow[a];
        {ceN, weN, oeN, ubN, lbN} = 5'(c);
        #1;
        rd    = !ceN && weN && !oeN;
        expOe = rd ? {~ubN, ~lbN} : 2'b00;
        expD  = {expOe[1] ? shadow[a][15:8] : 8'h00, expOe[0] ? shadow[a][7:0] : 8'h00};
        check({laneOe, dataOut} === {expOe, expD}, "R2 R4 R5 R6 R7 control sweep",
              {laneOe, dataOut}, {expOe, expD});
      end
      idle();
      doRead(18'(a), 0, 0, shadow[a], "R10 sweep intact");
    end

    // R8: high address bits alias onto low words
    for (int k = 1; k < 4; k++) begin
      int i;
      i = k * 37;
      shadow[i] = pat(i, k + 10);
      doWrite(18'(i + k * Depth + (1 << 17)), shadow[i], 0, 0);
      doRead(18'(i), 0, 0, shadow[i], "R8 alias low read");
      doRead(18'(i + 5 * Depth), 0, 0, shadow[i], "R8 alias high read");
    end

    // R9: write attempt during reset leaves word, contents survive reset
    doWrite(18'd7, ~shadow[7], 0, 0);
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check(laneOe === 2'b00, "R9 no drive in reset", {16'h0, laneOe}, 18'h0);
    idle();
    rstN = 1;
    doRead(18'd7, 0, 0, shadow[7], "R9 reset blocks write");

    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule